// File: doc/BRIEF.md
# Dual-Enable Registered Bus Transceiver

This block sits between two parallel data buses, A and B, and passes data in either direction or in both at once. Each direction has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low. Each direction also has its own storage register and a select that chooses between the other bus's live value and the stored value. Each bus is modelled as three vectors: the value seen from outside, the value the block would drive, and a per-bit drive enable. No tri-state nets are used.

Each storage register is loaded by a rising edge on its own capture strobe. The strobe is sampled on the system clock and loads the value its bus actually carries. When the block itself drives a bus, that bus carries the block's own output. This allows several moves that need no outside help. Live A data can be copied into both registers. Two stored words can be exchanged in one clock. One stored word can be copied into both registers by pulsing the strobes one after the other.

When both enables are asserted and both selects ask for live data, each bus would be driven from the other and the result is undefined. The block does not model that result. It releases both buses and raises a contention flag.

Top module: `dual_bus_tcvr`

## Requirements
- R1: A synchronous active-high reset clears both storage registers to zero. After reset, enabling both stored paths shows zero on both outputs.
- R2: `b_oe` is all ones when `en_ab` is 1 and is all zeros otherwise. `a_oe` is all ones when `en_ba_n` is 0 and is all zeros otherwise. Both exceptions come from R8. When `en_ab` is 0 and `en_ba_n` is 1, neither bus is driven. An output that is not driven reads zero.
- R3: On a driven side, a select of 0 passes the opposite bus input and a select of 1 passes the opposite storage register. The two directions are selected independently.
- R4: A storage register loads only in the clock cycle in which its strobe is first sampled high after being sampled low. A strobe held high loads once. Loading happens regardless of the enables and selects.
- R5: A register loads the resolved value of its own bus. That is the block's output when the block drives that bus, and the external input otherwise. For example, with B driven live from A, a B-side strobe loads the A input.
- R6: With both enables asserted and both selects at 1, rising edges on both strobes in the same cycle exchange the two stored words.
- R7: With both stored paths driving, a B-side strobe followed later by an A-side strobe leaves the original A-side word in both registers.
- R8: `clash` is 1 exactly when `en_ab`=1, `en_ba_n`=0, `sel_ab`=0 and `sel_ba`=0. While it is 1, both buses are released and any strobe loads the external inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | DATA_W | Value present on bus A |
| a_out | output | DATA_W | Value the block drives onto bus A |
| a_oe | output | DATA_W | Per-bit drive enable for bus A |
| b_in | input | DATA_W | Value present on bus B |
| b_out | output | DATA_W | Value the block drives onto bus B |
| b_oe | output | DATA_W | Per-bit drive enable for bus B |
| en_ab | input | 1 | A-to-B enable, active high |
| en_ba_n | input | 1 | B-to-A enable, active low |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A-side word |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B-side word |
| cap_a | input | 1 | Strobe for the register that stores bus A |
| cap_b | input | 1 | Strobe for the register that stores bus B |
| clash | output | 1 | Both directions requested live at once |

## Verification
The embedded properties watch a set of rules on every clock. They check that the buses are released during contention and isolation, that the live and stored paths route the right words, that each strobe gives only a one-cycle load pulse, and that a register loads only on that pulse and otherwise holds. Some properties only make sense across several strobes, so only the bench scenarios can show them. These are the one-clock exchange, the staggered copy into both registers, the live copy of A into the B-side register, and loading of external data while contention holds. The bench shows each of these by reading the stored words back through the stored paths.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

    typedef struct packed {
        logic en_ab;
        logic en_ba_n;
        logic sel_ab;
        logic sel_ba;
    } ctrl_t;

    typedef struct packed {
        logic drive_a;
        logic drive_b;
        logic clash;
    } drive_t;

    typedef enum logic [1:0] {
        SRC_OFF    = 2'd0,
        SRC_LIVE   = 2'd1,
        SRC_STORED = 2'd2
    } src_e;

    function automatic drive_t decode_drive(input ctrl_t c);
        drive_t d;
        d.clash   = c.en_ab & ~c.en_ba_n & ~c.sel_ab & ~c.sel_ba;
        d.drive_b = c.en_ab & ~d.clash;
        d.drive_a = ~c.en_ba_n & ~d.clash;
        return d;
    endfunction

    function automatic src_e pick_src(input logic drive, input logic sel);
        if (!drive)
            return SRC_OFF;
        return sel ? SRC_STORED : SRC_LIVE;
    endfunction

endpackage

// File: rtl/dbt_ctrl_decode.sv
module dbt_ctrl_decode
    import dbt_pkg::*;
(
    input  ctrl_t ctrl,
    output src_e  src_to_b,
    output src_e  src_to_a,
    output logic  clash
);

    drive_t drv;

    always_comb begin
        drv      = decode_drive(ctrl);
        src_to_b = pick_src(drv.drive_b, ctrl.sel_ab);
        src_to_a = pick_src(drv.drive_a, ctrl.sel_ba);
        clash    = drv.clash;
    end

endmodule

// File: rtl/dbt_edge_detect.sv
module dbt_edge_detect #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] lvl_q;

    always_ff @(posedge clk) begin
        lvl_q <= lvl;
    end

    assign rise = rst ? '0 : (lvl & ~lvl_q);

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r4_one_pulse: assert property (@(posedge clk) disable iff (rst)
            rise[i] |=> !rise[i]);
    end

endmodule

// File: rtl/dbt_store.sv
module dbt_store #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (cap)
            q <= d;
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> q == '0);

    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        cap |=> q == $past(d));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(q));

endmodule

// File: rtl/dbt_path_mux.sv
module dbt_path_mux
    import dbt_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  src_e         src,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] dout,
    output logic [W-1:0] oe
);

    always_comb begin
        unique case (src)
            SRC_LIVE: begin
                dout = live;
                oe   = '1;
            end
            SRC_STORED: begin
                dout = stored;
                oe   = '1;
            end
            default: begin
                dout = '0;
                oe   = '0;
            end
        endcase
    end

endmodule

// File: rtl/dual_bus_tcvr.sv
module dual_bus_tcvr
    import dbt_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic [DATA_W-1:0] a_oe,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic [DATA_W-1:0] b_oe,
    input  logic              en_ab,
    input  logic              en_ba_n,
    input  logic              sel_ab,
    input  logic              sel_ba,
    input  logic              cap_a,
    input  logic              cap_b,
    output logic              clash
);

    localparam int unsigned NSTROBE = 2;

    ctrl_t               ctrl;
    src_e                src_to_b;
    src_e                src_to_a;
    logic [NSTROBE-1:0]  rise;
    logic [DATA_W-1:0]   held_a;
    logic [DATA_W-1:0]   held_b;
    logic [DATA_W-1:0]   a_bus;
    logic [DATA_W-1:0]   b_bus;

    assign ctrl = '{en_ab: en_ab, en_ba_n: en_ba_n, sel_ab: sel_ab, sel_ba: sel_ba};

    dbt_ctrl_decode u_dec (
        .ctrl     (ctrl),
        .src_to_b (src_to_b),
        .src_to_a (src_to_a),
        .clash    (clash)
    );

    dbt_edge_detect #(.N(NSTROBE)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({cap_b, cap_a}),
        .rise (rise)
    );

    // Resolved bus: own drive wins bit by bit, otherwise the outside value.
    assign a_bus = (a_oe & a_out) | (~a_oe & a_in);
    assign b_bus = (b_oe & b_out) | (~b_oe & b_in);

    dbt_store #(.W(DATA_W)) u_store_a (
        .clk (clk),
        .rst (rst),
        .cap (rise[0]),
        .d   (a_bus),
        .q   (held_a)
    );

    dbt_store #(.W(DATA_W)) u_store_b (
        .clk (clk),
        .rst (rst),
        .cap (rise[1]),
        .d   (b_bus),
        .q   (held_b)
    );

    dbt_path_mux #(.W(DATA_W)) u_mux_to_b (
        .src    (src_to_b),
        .live   (a_in),
        .stored (held_a),
        .dout   (b_out),
        .oe     (b_oe)
    );

    dbt_path_mux #(.W(DATA_W)) u_mux_to_a (
        .src    (src_to_a),
        .live   (b_in),
        .stored (held_b),
        .dout   (a_out),
        .oe     (a_oe)
    );

    a_r8_clash_releases: assert property (@(posedge clk) disable iff (rst)
        clash |-> (a_oe == '0 && b_oe == '0));

    a_r2_isolation: assert property (@(posedge clk) disable iff (rst)
        (!en_ab && en_ba_n) |-> (a_oe == '0 && b_oe == '0 && !clash));

    a_r3_live_to_b: assert property (@(posedge clk) disable iff (rst)
        (en_ab && !sel_ab && !clash) |-> b_out == a_in);

    a_r3_stored_to_a: assert property (@(posedge clk) disable iff (rst)
        (!en_ba_n && sel_ba) |-> a_out == held_b);

    a_r5_self_capture: assert property (@(posedge clk) disable iff (rst)
        (rise[1] && b_oe == '1) |=> held_b == $past(b_out));

endmodule

// File: tb/dual_bus_tcvr_test.sv
`timescale 1ns/1ps
module dual_bus_tcvr_test;

    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         en_ab, en_ba_n, sel_ab, sel_ba, cap_a, cap_b;
    logic         clash;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] ma, mb;
    logic         pa, pb;

    always #10 clk = ~clk;

    dual_bus_tcvr #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .cap_a(cap_a), .cap_b(cap_b), .clash(clash)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cap_a = 1'b0; cap_b = 1'b0;
        en_ab = 1'b0; en_ba_n = 1'b1; sel_ab = 1'b0; sel_ba = 1'b0;
        a_in = '0; b_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ma = '0; mb = '0; pa = 1'b0; pb = 1'b0;
    endtask

    task automatic apply(input logic eab, input logic ebn, input logic sab, input logic sba,
                         input logic ca, input logic cb,
                         input logic [W-1:0] av, input logic [W-1:0] bv, input string tag);
        logic         cl, da, db;
        logic [W-1:0] ao, bo, abus, bbus, na, nb;
        @(negedge clk);
        en_ab = eab; en_ba_n = ebn; sel_ab = sab; sel_ba = sba;
        cap_a = ca; cap_b = cb; a_in = av; b_in = bv;
        #2;
        cl = eab & ~ebn & ~sab & ~sba;
        db = eab & ~cl;
        da = ~ebn & ~cl;
        bo = db ? (sab ? ma : av) : '0;
        ao = da ? (sba ? mb : bv) : '0;
        chk({tag, " clash"}, W'(clash), W'(cl));
        chk({tag, " b_oe"}, b_oe, db ? '1 : '0);
        chk({tag, " a_oe"}, a_oe, da ? '1 : '0);
        chk({tag, " b_out"}, b_out, bo);
        chk({tag, " a_out"}, a_out, ao);
        abus = da ? ao : av;
        bbus = db ? bo : bv;
        na = (ca && !pa) ? abus : ma;
        nb = (cb && !pb) ? bbus : mb;
        ma = na; mb = nb; pa = ca; pb = cb;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        do_reset();

        // R1: stored paths show zero right after reset
        apply(1, 0, 1, 1, 0, 0, 8'h5A, 8'hC3, "R1");
        chk("R1 stored A after reset", b_out, 8'h00);
        chk("R1 stored B after reset", a_out, 8'h00);

        // Sweep of all control combinations with strobe and data patterns (R2 R3 R4 R5 R8)
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 4; p++) begin
                apply(c[0], c[1], c[2], c[3], p[0] ^ c[2], p[1] ^ c[3],
                      W'(c * 37 + p * 91 + 5), W'((c * 53) ^ (p * 29) ^ 8'hC3),
                      "R2 R3 R4 R5 R8 sweep");
            end
        end

        // R4: load while isolated, held strobe does not reload
        do_reset();
        apply(0, 1, 0, 0, 1, 1, 8'h3C, 8'hA5, "R4");
        apply(0, 1, 0, 0, 1, 1, 8'h99, 8'h66, "R4");
        apply(0, 1, 0, 0, 0, 0, 8'h00, 8'h00, "R4");
        apply(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R3");
        chk("R4 held strobe A", b_out, 8'h3C);
        chk("R4 held strobe B", a_out, 8'hA5);

        // R6: exchange in one clock
        apply(1, 0, 1, 1, 1, 1, 8'h00, 8'h00, "R6");
        apply(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R6");
        chk("R6 exchange to B", b_out, 8'hA5);
        chk("R6 exchange to A", a_out, 8'h3C);

        // R7: staggered strobes copy the A-side word into both registers
        apply(1, 0, 1, 1, 0, 1, 8'h00, 8'h00, "R7");
        apply(1, 0, 1, 1, 1, 0, 8'h00, 8'h00, "R7");
        apply(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R7");
        chk("R7 A side", b_out, 8'hA5);
        chk("R7 B side", a_out, 8'hA5);

        // R5: live A onto B, B strobe loads A data; then A strobe
        apply(1, 1, 0, 0, 0, 1, 8'h77, 8'h11, "R5");
        apply(1, 1, 0, 0, 1, 0, 8'h77, 8'h11, "R5");
        apply(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R5");
        chk("R5 A in B register", a_out, 8'h77);
        chk("R5 A in A register", b_out, 8'h77);

        // R8: contention flags, releases, loads external values
        apply(1, 0, 0, 0, 1, 1, 8'h0F, 8'hF0, "R8");
        chk("R8 clash flag", W'(clash), W'(1'b1));
        chk("R8 b released", b_oe, 8'h00);
        chk("R8 a released", a_oe, 8'h00);
        apply(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R8");
        chk("R8 external A loaded", b_out, 8'h0F);
        chk("R8 external B loaded", a_out, 8'hF0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule